// File: doc/BRIEF.md
# Programmable Chip-Select Generator

This block watches every bus cycle and compares it against a small set of programmable select channels. Each channel holds two 16-bit registers. The window register sets an address window: a base and a block size from 2 KiB up to 1 MiB. The qualifier register holds the direction, byte-lane, address-space, interrupt-level and strobe-timing conditions, plus a termination code. A channel drives its active-low select pin low only when the cycle meets all of its conditions.

The block can also end the cycle by itself. After the number of wait states that the termination code gives, it raises an internal acknowledge. That acknowledge comes from the lowest-numbered matching channel. It can also report a 16-bit port width and an autovector request.

A per-pin assignment field gives each channel's pin one of four uses: a discrete output level, a pass-through of an alternate-function source, or the select itself. The select can be for an 8-bit or a 16-bit port. Configuration is written through a simple word-wide register port. The same port reads back a registered copy of any register.

Top module: `csel_decoder`

## Requirements
- R1: Window register bits 15:3 hold address bits 23:11 and bits 2:0 hold the block size. The size codes 0..7 give 2K, 8K, 16K, 64K, 128K, 256K, 512K and 1M. Only the address bits at or above the block size are compared with the base.
- R2: Qualifier bits 12:11 set the direction. Bit 11 permits reads and bit 12 permits writes, so 01 means read only, 10 write only and 11 both. With 00 the channel never matches.
- R3: Qualifier bits 14:13 set the byte lanes. 00 is disabled and never selects. 01 needs the lower lane (`bus_lane_i[0]`), 10 the upper lane (`bus_lane_i[1]`), and 11 accepts either.
- R4: Qualifier bits 5:4 are compared with `bus_space_i`. 00 matches CPU space (00), 01 user (01), 10 supervisor (10), and 11 matches user or supervisor.
- R5: In a CPU-space channel, qualifier bits 3:1 must equal `bus_ilvl_i`, unless they are zero, which matches any level. Channels for other spaces ignore the level.
- R6: With qualifier bit 10 clear, a select follows the address strobe. With it set, the data strobe is also needed. A select pin goes low at the first clock edge after the edge that samples the qualifying inputs.
- R7: Assignment bits [2i+1:2i] set pin i. 00 drives discrete data bit i, 01 passes `alt_i[i]` through, and 10 or 11 makes the pin the active-low select. The pin is registered.
- R8: Assignment-register bits above 2*NCH read as zero and ignore writes. Configuration kinds are `cfg_addr_i` top bits: 0 window, 1 qualifier, 2 assignment, 3 discrete data.
- R9: When several channels match one cycle, every matching select pin goes low.
- R10: Let edge k be the first edge that samples `bus_as_i` high. Termination code n (0..13) raises `ack_o` at edge k+1+n. Code 14 raises it at edge k. Code 15, or a cycle with no match, never raises it.
- R11: The acknowledge follows the lowest-numbered matching channel. `ack_wide_o` is high with it when that channel's assignment is 11.
- R12: `avec_o` is high with `ack_o` when the winning channel has qualifier bit 0 set and the cycle is in CPU space.
- R13: `ack_o` drops at the first edge after `bus_as_i` is sampled low. Reset drives every pin high, `ack_o` low and `cfg_rdata_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2+IDX_W | Register kind (top 2 bits) and channel index |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Registered read data for `cfg_addr_i` |
| bus_as_i | input | 1 | Address strobe, active high |
| bus_ds_i | input | 1 | Data strobe, active high |
| bus_rd_i | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_lane_i | input | 2 | Requested byte lanes {upper, lower} |
| bus_space_i | input | 2 | Address space: 00 CPU, 01 user, 10 supervisor |
| bus_ilvl_i | input | 3 | Interrupt level of a CPU-space cycle |
| bus_addr_i | input | ADDR_W | Bus address |
| alt_i | input | NCH | Alternate-function sources per pin |
| cs_pin_o | output | NCH | Registered pin levels (active-low selects) |
| ack_o | output | 1 | Internal termination acknowledge |
| ack_wide_o | output | 1 | Acknowledge is for a 16-bit port |
| avec_o | output | 1 | Autovector request with the acknowledge |

## Verification
A corrupted window or qualifier register shows up one edge after the next bus cycle's address is sampled. The wrong pin goes low, or the right pin stays high. Each condition (window edge, direction, lane, space, level) is therefore probed with cycles that hit and miss on one condition at a time. A stale wait counter or a wrong priority choice shows up only in the acknowledge: it arrives on the wrong edge, or it carries the wrong width or autovector flag. For that reason the acknowledge is compared on every edge of each cycle, and again on the edge after the strobe drops.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int unsigned REG_W        = 16;
  localparam int unsigned MIN_BLK_LOG2 = 11;

  // configuration register kinds (upper cfg address bits)
  typedef enum logic [1:0] {
    CFG_WIN    = 2'd0,
    CFG_QUAL   = 2'd1,
    CFG_ASSIGN = 2'd2,
    CFG_DISC   = 2'd3
  } cfg_kind_e;

  // qualifier register bit positions
  localparam int unsigned Q_AVEC    = 0;
  localparam int unsigned Q_LVL_LO  = 1;
  localparam int unsigned Q_SPC_LO  = 4;
  localparam int unsigned Q_TERM_LO = 6;
  localparam int unsigned Q_STRB    = 10;
  localparam int unsigned Q_DIR_LO  = 11;
  localparam int unsigned Q_LANE_LO = 13;

  localparam logic [3:0] TERM_FAST = 4'd14;
  localparam logic [3:0] TERM_EXT  = 4'd15;

  typedef struct packed {
    logic       as;
    logic       ds;
    logic       rd;
    logic [1:0] lane;
    logic [1:0] space;
    logic [2:0] ilvl;
  } bus_ctl_t;

  // block-size code to log2 of window size in bytes
  function automatic logic [4:0] blk_log2(input logic [2:0] code);
    logic [4:0] r;
    case (code)
      3'd0:    r = 5'd11;
      3'd1:    r = 5'd13;
      3'd2:    r = 5'd14;
      3'd3:    r = 5'd16;
      3'd4:    r = 5'd17;
      3'd5:    r = 5'd18;
      3'd6:    r = 5'd19;
      default: r = 5'd20;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
#(
  parameter int NCH = 4,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AS_W  = 2 * NCH
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       cfg_we_i,
  input  logic [IDX_W+1:0]           cfg_addr_i,
  input  logic [REG_W-1:0]           cfg_wdata_i,
  output logic [REG_W-1:0]           cfg_rdata_o,
  output logic [NCH-1:0][REG_W-1:0]  win_o,
  output logic [NCH-1:0][REG_W-1:0]  qual_o,
  output logic [AS_W-1:0]            asg_o,
  output logic [NCH-1:0]             disc_o
);

  logic [NCH-1:0][REG_W-1:0] win_q, qual_q;
  logic [AS_W-1:0]           asg_q;
  logic [NCH-1:0]            disc_q;
  logic [REG_W-1:0]          rdata_q, rd_v;
  cfg_kind_e                 kind;
  logic [IDX_W-1:0]          idx;
  logic                      idx_ok;

  assign kind   = cfg_kind_e'(cfg_addr_i[IDX_W+1:IDX_W]);
  assign idx    = cfg_addr_i[IDX_W-1:0];
  assign idx_ok = ({1'b0, idx} < (IDX_W+1)'(NCH));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      win_q  <= '0;
      qual_q <= '0;
      asg_q  <= '0;
      disc_q <= '1;
    end else if (cfg_we_i) begin
      case (kind)
        CFG_WIN:    if (idx_ok) win_q[idx]  <= cfg_wdata_i;
        CFG_QUAL:   if (idx_ok) qual_q[idx] <= cfg_wdata_i;
        CFG_ASSIGN: asg_q  <= cfg_wdata_i[AS_W-1:0];
        default:    disc_q <= cfg_wdata_i[NCH-1:0];
      endcase
    end
  end

  always_comb begin
    rd_v = '0;
    case (kind)
      CFG_WIN:    if (idx_ok) rd_v = win_q[idx];
      CFG_QUAL:   if (idx_ok) rd_v = qual_q[idx];
      CFG_ASSIGN: rd_v[AS_W-1:0] = asg_q;
      default:    rd_v[NCH-1:0]  = disc_q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_q <= '0;
    else       rdata_q <= rd_v;
  end

  assign cfg_rdata_o = rdata_q;
  assign win_o       = win_q;
  assign qual_o      = qual_q;
  assign asg_o       = asg_q;
  assign disc_o      = disc_q;

  generate
    if (AS_W < REG_W) begin : g_hi_chk
      // R8: unused assignment bits always read back as zero
      a_r8_assign_hi_zero : assert property (@(posedge clk_i) disable iff (rst_i)
        (kind == CFG_ASSIGN) |=> (cfg_rdata_o[REG_W-1:AS_W] == '0));
    end
  endgenerate

endmodule

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
#(
  parameter int ADDR_W = 24,
  localparam int HI_W  = ADDR_W - MIN_BLK_LOG2
) (
  input  logic [REG_W-1:0]  win_i,
  input  logic [REG_W-1:0]  qual_i,
  input  logic [1:0]        asg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  bus_ctl_t          bus_i,
  output logic              hit_o,
  output logic              sel_o
);

  logic [4:0]      lg;
  logic [HI_W-1:0] keep;
  logic [HI_W-1:0] diff;
  logic            addr_ok, dir_ok, lane_ok, spc_ok, lvl_ok;
  logic [1:0]      spc;
  logic [2:0]      lvl;

  assign lg   = blk_log2(win_i[2:0]);
  assign diff = addr_i[ADDR_W-1:MIN_BLK_LOG2] ^ win_i[3 +: HI_W];
  assign spc  = qual_i[Q_SPC_LO +: 2];
  assign lvl  = qual_i[Q_LVL_LO +: 3];

  always_comb begin
    for (int j = 0; j < HI_W; j++)
      keep[j] = ((j + MIN_BLK_LOG2) >= int'(lg));
  end

  assign addr_ok = ((diff & keep) == '0);
  assign dir_ok  = bus_i.rd ? qual_i[Q_DIR_LO] : qual_i[Q_DIR_LO+1];
  assign lane_ok = |(qual_i[Q_LANE_LO +: 2] & bus_i.lane);

  always_comb begin
    case (spc)
      2'b00:   spc_ok = (bus_i.space == 2'b00);
      2'b01:   spc_ok = (bus_i.space == 2'b01);
      2'b10:   spc_ok = (bus_i.space == 2'b10);
      default: spc_ok = (bus_i.space == 2'b01) || (bus_i.space == 2'b10);
    endcase
  end

  assign lvl_ok = (spc != 2'b00) || (lvl == 3'd0) || (lvl == bus_i.ilvl);

  assign hit_o = bus_i.as & asg_i[1] & addr_ok & dir_ok & lane_ok & spc_ok & lvl_ok;
  assign sel_o = hit_o & (~qual_i[Q_STRB] | bus_i.ds);

endmodule

// File: rtl/csel_term.sv
module csel_term
  import csel_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                as_i,
  input  logic [NCH-1:0]      hit_i,
  input  logic [NCH-1:0][3:0] code_i,
  input  logic [NCH-1:0]      wide_i,
  input  logic [NCH-1:0]      avec_i,
  output logic                ack_o,
  output logic                wide_o,
  output logic                avec_o
);

  typedef enum logic [1:0] {T_IDLE, T_WAIT, T_DONE} tstate_e;

  tstate_e    st_q;
  logic [3:0] cnt_q;
  logic       ack_q, wide_q, avec_q;
  logic       win_any, win_wide, win_avec;
  logic [3:0] win_code;

  // lowest index wins: scan downward so the last write is the lowest hit
  always_comb begin
    win_any  = 1'b0;
    win_code = 4'd0;
    win_wide = 1'b0;
    win_avec = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        win_any  = 1'b1;
        win_code = code_i[i];
        win_wide = wide_i[i];
        win_avec = avec_i[i];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q   <= T_IDLE;
      cnt_q  <= '0;
      ack_q  <= 1'b0;
      wide_q <= 1'b0;
      avec_q <= 1'b0;
    end else if (!as_i) begin
      st_q  <= T_IDLE;
      ack_q <= 1'b0;
    end else begin
      case (st_q)
        T_IDLE: begin
          wide_q <= win_wide;
          avec_q <= win_avec;
          if (!win_any || win_code == TERM_EXT) begin
            st_q <= T_DONE;
          end else if (win_code == TERM_FAST) begin
            ack_q <= 1'b1;
            st_q  <= T_DONE;
          end else begin
            cnt_q <= win_code;
            st_q  <= T_WAIT;
          end
        end
        T_WAIT: begin
          if (cnt_q == 4'd0) begin
            ack_q <= 1'b1;
            st_q  <= T_DONE;
          end else begin
            cnt_q <= cnt_q - 4'd1;
          end
        end
        default: st_q <= T_DONE;
      endcase
    end
  end

  assign ack_o  = ack_q;
  assign wide_o = ack_q & wide_q;
  assign avec_o = ack_q & avec_q;

  // R13: acknowledge falls once the strobe is gone
  a_r13_ack_drops : assert property (@(posedge clk_i) disable iff (rst_i)
    !as_i |=> !ack_o);

  // R10: external-termination code never self-acknowledges at cycle start
  a_r10_external_silent : assert property (@(posedge clk_i) disable iff (rst_i)
    (as_i && st_q == T_IDLE && win_any && win_code == TERM_EXT) |=> !ack_o);

endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 24,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W+1:0]  cfg_addr_i,
  input  logic [15:0]       cfg_wdata_i,
  output logic [15:0]       cfg_rdata_o,
  input  logic              bus_as_i,
  input  logic              bus_ds_i,
  input  logic              bus_rd_i,
  input  logic [1:0]        bus_lane_i,
  input  logic [1:0]        bus_space_i,
  input  logic [2:0]        bus_ilvl_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NCH-1:0]    alt_i,
  output logic [NCH-1:0]    cs_pin_o,
  output logic              ack_o,
  output logic              ack_wide_o,
  output logic              avec_o
);

  localparam int AS_W = 2 * NCH;

  logic [NCH-1:0][REG_W-1:0] win, qual;
  logic [AS_W-1:0]           asg;
  logic [NCH-1:0]            disc;
  logic [NCH-1:0]            hit, sel, wide, avec, cs_mask;
  logic [NCH-1:0][3:0]       code;
  logic [NCH-1:0]            pin_q;
  bus_ctl_t                  bus;

  assign bus = '{as: bus_as_i, ds: bus_ds_i, rd: bus_rd_i, lane: bus_lane_i,
                 space: bus_space_i, ilvl: bus_ilvl_i};

  csel_regs #(.NCH(NCH)) regs_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .win_o       (win),
    .qual_o      (qual),
    .asg_o       (asg),
    .disc_o      (disc)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      csel_match #(.ADDR_W(ADDR_W)) match_i (
        .win_i  (win[i]),
        .qual_i (qual[i]),
        .asg_i  (asg[2*i +: 2]),
        .addr_i (bus_addr_i),
        .bus_i  (bus),
        .hit_o  (hit[i]),
        .sel_o  (sel[i])
      );
      assign code[i]    = qual[i][Q_TERM_LO +: 4];
      assign wide[i]    = (asg[2*i +: 2] == 2'b11);
      assign avec[i]    = qual[i][Q_AVEC] & (bus_space_i == 2'b00);
      assign cs_mask[i] = asg[2*i+1];

      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          pin_q[i] <= 1'b1;
        end else begin
          case (asg[2*i +: 2])
            2'b00:   pin_q[i] <= disc[i];
            2'b01:   pin_q[i] <= alt_i[i];
            default: pin_q[i] <= ~sel[i];
          endcase
        end
      end

      // R9: every qualifying select channel pulls its own pin low next edge
      a_r9_sel_drives_pin : assert property (@(posedge clk_i) disable iff (rst_i)
        (sel[i] && cs_mask[i] && !cfg_we_i) |=> !cs_pin_o[i]);
    end
  endgenerate

  csel_term #(.NCH(NCH)) term_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .as_i   (bus_as_i),
    .hit_i  (hit),
    .code_i (code),
    .wide_i (wide),
    .avec_i (avec),
    .ack_o  (ack_o),
    .wide_o (ack_wide_o),
    .avec_o (avec_o)
  );

  assign cs_pin_o = pin_q;

  // R13: with no strobe, every select-assigned pin is idle high next edge
  a_r13_idle_pins : assert property (@(posedge clk_i) disable iff (rst_i)
    (!bus_as_i && !cfg_we_i) |=> ((cs_pin_o | ~cs_mask) == '1));

  // R12: an autovector request only rides on an acknowledge
  a_r12_avec_with_ack : assert property (@(posedge clk_i) disable iff (rst_i)
    avec_o |-> ack_o);

endmodule

// File: tb/csel_decoder_tb_top.sv
module csel_decoder_tb_top;

  localparam int NCH    = 4;
  localparam int ADDR_W = 24;
  localparam int IDX_W  = 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              cfg_we;
  logic [IDX_W+1:0]  cfg_addr;
  logic [15:0]       cfg_wdata;
  logic [15:0]       cfg_rdata;
  logic              bus_as, bus_ds, bus_rd;
  logic [1:0]        bus_lane, bus_space;
  logic [2:0]        bus_ilvl;
  logic [ADDR_W-1:0] bus_addr;
  logic [NCH-1:0]    alt;
  logic [NCH-1:0]    pins;
  logic              ack, ack_wide, avec;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  csel_decoder #(.NCH(NCH), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_i(rst), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .bus_as_i(bus_as),
    .bus_ds_i(bus_ds), .bus_rd_i(bus_rd), .bus_lane_i(bus_lane),
    .bus_space_i(bus_space), .bus_ilvl_i(bus_ilvl), .bus_addr_i(bus_addr),
    .alt_i(alt), .cs_pin_o(pins), .ack_o(ack), .ack_wide_o(ack_wide), .avec_o(avec)
  );

  // scoreboard items: kind 0 = pins, 1 = {ack, wide, avec}, 2 = read data
  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];

  task automatic push(input int kind, input logic [15:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = {12'd0, pins};
        1:       act = {13'd0, ack, ack_wide, avec};
        default: act = cfg_rdata;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] kind, input logic [1:0] idx, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {kind, idx}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] kind, input logic [1:0] idx,
                        input logic [15:0] exp, input string req);
    @(negedge clk);
    cfg_addr = {kind, idx};
    @(posedge clk);
    push(2, exp, req);
  endtask

  task automatic pin_chk(input logic [3:0] exp, input string req);
    @(posedge clk);
    push(0, {12'd0, exp}, req);
  endtask

  // one bus cycle; ackpos < 0 means no acknowledge expected
  task automatic bus_cycle(input logic [23:0] a, input logic rd, input logic [1:0] lane,
                           input logic [1:0] sp, input logic [2:0] il, input int len,
                           input logic [3:0] exp_k0, input logic [3:0] exp_p,
                           input int ackpos, input logic w, input logic av,
                           input string req);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_lane = lane; bus_space = sp; bus_ilvl = il;
    bus_as = 1'b1; bus_ds = 1'b0;
    @(posedge clk);
    push(0, {12'd0, exp_k0}, req);
    push(1, (ackpos == 0) ? {13'd0, 1'b1, w, av} : 16'd0, req);
    @(negedge clk);
    bus_ds = 1'b1;
    for (int j = 1; j < len; j++) begin
      @(posedge clk);
      push(0, {12'd0, exp_p}, req);
      push(1, (ackpos >= 0 && j >= ackpos) ? {13'd0, 1'b1, w, av} : 16'd0, req);
    end
    @(negedge clk);
    bus_as = 1'b0; bus_ds = 1'b0;
    @(posedge clk);
    push(0, 16'h000F, "R13 idle pins");
    push(1, 16'h0000, "R13 ack drop");
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    bus_as = 1'b0; bus_ds = 1'b0; bus_rd = 1'b0; bus_lane = '0; bus_space = '0;
    bus_ilvl = '0; bus_addr = '0; alt = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    push(0, 16'h000F, "R13 reset pins");
    push(1, 16'h0000, "R13 reset ack");
    push(2, 16'h0000, "R13 reset rdata");

    // R7 discrete and alternate-function pins
    wr(2'd3, 2'd0, 16'h000A);
    pin_chk(4'b1010, "R7 discrete");
    wr(2'd2, 2'd0, 16'h0001);
    @(negedge clk); alt = 4'b0001;
    pin_chk(4'b1011, "R7 alternate high");
    @(negedge clk); alt = 4'b0000;
    pin_chk(4'b1010, "R7 alternate low");

    // R8 unused assignment bits
    wr(2'd2, 2'd0, 16'hFFFF);
    rd_chk(2'd2, 2'd0, 16'h00FF, "R8 assign readback");

    // program channels
    wr(2'd0, 2'd0, 16'h1003); wr(2'd1, 2'd0, 16'h78B0);
    wr(2'd0, 2'd1, 16'h1000); wr(2'd1, 2'd1, 16'h2FA0);
    wr(2'd0, 2'd2, 16'hF007); wr(2'd1, 2'd2, 16'h680B);
    wr(2'd0, 2'd3, 16'h2001); wr(2'd1, 2'd3, 16'h53D0);
    wr(2'd2, 2'd0, 16'h00BB);
    rd_chk(2'd2, 2'd0, 16'h00BB, "R8 assign value");
    rd_chk(2'd1, 2'd1, 16'h2FA0, "R8 qualifier readback");
    pin_chk(4'b1111, "R7 select pins idle");

    bus_cycle(24'h100010, 1, 2'b11, 2'b10, 0, 5, 4'b1110, 4'b1100, 3, 1, 0, "R9 R11 R6 double hit");
    bus_cycle(24'h100010, 0, 2'b11, 2'b10, 0, 5, 4'b1110, 4'b1110, 3, 1, 0, "R2 write skips read-only");
    bus_cycle(24'h110000, 1, 2'b11, 2'b10, 0, 4, 4'b1111, 4'b1111, -1, 0, 0, "R1 above 64K window");
    bus_cycle(24'h10FFFE, 1, 2'b11, 2'b10, 0, 5, 4'b1110, 4'b1110, 3, 1, 0, "R1 top of 64K window");
    bus_cycle(24'h100010, 1, 2'b10, 2'b10, 0, 5, 4'b1110, 4'b1110, 3, 1, 0, "R3 upper lane only");
    wr(2'd1, 2'd0, 16'h18B0);
    bus_cycle(24'h100010, 1, 2'b01, 2'b10, 0, 4, 4'b1111, 4'b1101, 0, 0, 0, "R10 R3 fast term disabled lanes");
    bus_cycle(24'hF12345, 1, 2'b11, 2'b00, 5, 4, 4'b1011, 4'b1011, 1, 1, 1, "R5 R12 level match");
    bus_cycle(24'hF12345, 1, 2'b11, 2'b00, 3, 4, 4'b1111, 4'b1111, -1, 0, 0, "R5 level mismatch");
    bus_cycle(24'h201FFE, 0, 2'b10, 2'b01, 0, 5, 4'b0111, 4'b0111, -1, 0, 0, "R10 external term");
    bus_cycle(24'h201FFE, 1, 2'b10, 2'b01, 0, 4, 4'b1111, 4'b1111, -1, 0, 0, "R2 read skips write-only");
    bus_cycle(24'h202000, 0, 2'b10, 2'b01, 0, 4, 4'b1111, 4'b1111, -1, 0, 0, "R1 above 8K window");
    wr(2'd1, 2'd0, 16'h78B0);
    bus_cycle(24'h100800, 0, 2'b11, 2'b01, 0, 5, 4'b1110, 4'b1110, 3, 1, 0, "R4 user on both-space channel");
    bus_cycle(24'h100010, 1, 2'b01, 2'b01, 0, 5, 4'b1110, 4'b1110, 3, 1, 0, "R4 user skips supervisor channel");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule